// File: doc/BRIEF.md
# Stopwatch Timing Core

This block keeps a running time of up to one hour with one-hundredth-of-a-second resolution. It runs from a single system clock. An internal prescaler divides that clock into single-cycle enables; no derived clocks are used. The time is held as six BCD digits in minutes, seconds and hundredths. The count goes from 00:00.00 up to 59:59.99, and the next step returns it to 00:00.00.

A single start/stop input toggles the block between running and paused on each rising edge. An active-low clear input stops the count and reloads the time. The block also produces a free-running 1 kHz enable pulse that a downstream multiplexed display can use to step through its digits. The button input is expected to be debounced already. The clear input is expected to be synchronous to the clock.

Top module: `stopwatch_core`

## Requirements
- R1: While `rst_n` is low, `bcd_time` equals `CLR_VALUE` (zero by default) and the block is paused. The same value and the paused state apply on the first edge after `clr_n` is sampled low.
- R2: `scan_tick` is high for one clock in every `CLK_HZ/1000` clocks. It keeps running whether the count is running or paused.
- R3: An internal counting tick occurs on every tenth `scan_tick`. While running, each counting tick advances the time by exactly one hundredth of a second.
- R4: The hundredths, tenths, seconds-units and minutes-units digits step 0 to 9 and pass a carry when they wrap from 9. The seconds-tens and minutes-tens digits step 0 to 5 and pass a carry when they wrap from 5. A digit changes only on a carry from the digit below it, so 00:09.99 is followed by 00:10.00.
- R5: The counting tick after 59:59.99 sets every digit to zero.
- R6: A rising edge on `start_stop` toggles between running and paused. The first edge after reset or clear starts counting. The toggle takes effect three clock edges after the edge on which the high level is first sampled.
- R7: While paused, `bcd_time` holds its value across any number of counting ticks.
- R8: While `clr_n` is low, both prescaler counters are held at zero. The first `scan_tick` after release appears `CLK_HZ/1000` clocks after the last clearing edge.
- R9: `bcd_time` packs the digits in nibbles from most to least significant: [23:20] minutes tens, [19:16] minutes units, [15:12] seconds tens, [11:8] seconds units, [7:4] tenths, [3:0] hundredths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low clear of time, run state and prescaler |
| start_stop | input | 1 | Debounced button; each rising edge toggles run/pause |
| bcd_time | output | 24 | Six packed BCD digits, minutes tens in the top nibble |
| scan_tick | output | 1 | Single-cycle 1 kHz enable for display scanning |

## Verification
`scan_tick` is decoded from the prescaler register. It is therefore due in the same cycle the counter reaches its last value. `bcd_time` changes on the rising edge where a counting tick meets the running state. A `start_stop` edge first changes the counting on the third rising edge after it is sampled, after the two synchronizer flops and the edge register. A clear acts on the next edge. The bench steps a behavioural model on every rising edge, with the same register count per path, and compares both outputs on each falling edge. Named checks wait for a specific value, then sample the output one falling edge after the change is due.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;
   localparam int NUM_DIGITS = 6;
   localparam int DIGIT_W    = 4;
   localparam int TIME_W     = NUM_DIGITS * DIGIT_W;

   typedef logic [DIGIT_W-1:0] bcd_digit_t;

   // Digit index 0 is hundredths; indices 3 and 5 are the tens of seconds and minutes.
   function automatic int digit_radix(input int idx);
      return (idx == 3 || idx == 5) ? 6 : 10;
   endfunction
endpackage

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
   parameter int CLK_HZ    = 48_000_000,
   parameter int SCAN_HZ   = 1000,
   parameter int COUNT_DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_n,
   output logic scan_tick,
   output logic count_tick
);
   localparam int SCAN_DIV = CLK_HZ / SCAN_HZ;
   localparam int PRE_W    = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
   localparam int DEC_W    = (COUNT_DIV > 1) ? $clog2(COUNT_DIV) : 1;
   localparam logic [DEC_W-1:0] DEC_LAST = DEC_W'(COUNT_DIV - 1);

   if (SCAN_HZ < 1 || CLK_HZ % SCAN_HZ != 0 || SCAN_DIV < 1)
      $error("CLK_HZ must be a positive multiple of SCAN_HZ");
   if (COUNT_DIV < 1)
      $error("COUNT_DIV must be at least 1");

   logic [DEC_W-1:0] dec_q;

   if (SCAN_DIV == 1) begin : g_direct
      assign scan_tick = 1'b1;
   end else begin : g_counted
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SCAN_DIV - 1);
      logic [PRE_W-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                pre_q <= '0;
         else if (!clr_n)           pre_q <= '0;
         else if (pre_q == PRE_LAST) pre_q <= '0;
         else                       pre_q <= pre_q + 1'b1;
      end

      assign scan_tick = (pre_q == PRE_LAST);

      a_r2_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
         pre_q <= PRE_LAST);
      a_r8_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
         !clr_n |=> !scan_tick);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dec_q <= '0;
      else if (!clr_n)    dec_q <= '0;
      else if (scan_tick) dec_q <= (dec_q == DEC_LAST) ? '0 : dec_q + 1'b1;
   end

   assign count_tick = scan_tick && (dec_q == DEC_LAST);

   a_r3_dec_range: assert property (@(posedge clk) disable iff (!rst_n)
      dec_q <= DEC_LAST);
   a_r3_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !scan_tick) |=> $stable(dec_q));
endmodule

// File: rtl/sw_runctl.sv
module sw_runctl #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_n,
   input  logic btn,
   output logic running
);
   if (SYNC_STAGES < 2)
      $error("SYNC_STAGES must be at least 2");

   // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its previous value
   logic [SYNC_STAGES:0] chain_q;
   logic                 press;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[SYNC_STAGES-1:0], btn};
   end

   assign press = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      running <= 1'b0;
      else if (!clr_n) running <= 1'b0;
      else if (press)  running <= ~running;
   end

   a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && press) |=> (running != $past(running)));
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !press) |=> $stable(running));
   a_r1_clear_pauses: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> !running);
endmodule

// File: rtl/sw_digit.sv
module sw_digit
   import stopwatch_pkg::*;
#(
   parameter int RADIX = 10,
   parameter int INIT  = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_n,
   input  logic       cin,
   output logic       cout,
   output bcd_digit_t value
);
   localparam bcd_digit_t TOP  = bcd_digit_t'(RADIX - 1);
   localparam bcd_digit_t LOAD = bcd_digit_t'(INIT);

   if (RADIX < 2 || RADIX > 10)
      $error("RADIX out of BCD range");
   if (INIT < 0 || INIT >= RADIX)
      $error("INIT digit exceeds its radix");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      value <= LOAD;
      else if (!clr_n) value <= LOAD;
      else if (cin)    value <= (value == TOP) ? '0 : value + 1'b1;
   end

   assign cout = cin && (value == TOP);

   a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
      value <= TOP);
   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && cin && value == TOP) |=> value == '0);
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !cin) |=> $stable(value));
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
   import stopwatch_pkg::*;
#(
   parameter int              CLK_HZ    = 48_000_000,
   parameter int              COUNT_DIV = 10,
   parameter logic [TIME_W-1:0] CLR_VALUE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_n,
   input  logic              start_stop,
   output logic [TIME_W-1:0] bcd_time,
   output logic              scan_tick
);
   logic                count_tick;
   logic                running;
   logic [NUM_DIGITS:0] carry;

   sw_prescaler #(.CLK_HZ(CLK_HZ), .SCAN_HZ(1000), .COUNT_DIV(COUNT_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
      .scan_tick(scan_tick), .count_tick(count_tick)
   );

   sw_runctl #(.SYNC_STAGES(2)) u_run (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
      .btn(start_stop), .running(running)
   );

   assign carry[0] = count_tick && running;

   for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
      sw_digit #(
         .RADIX(digit_radix(i)),
         .INIT(int'(CLR_VALUE[i*DIGIT_W +: DIGIT_W]))
      ) u_dig (
         .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
         .cin(carry[i]), .cout(carry[i+1]),
         .value(bcd_time[i*DIGIT_W +: DIGIT_W])
      );
   end

   a_r5_rollover: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && carry[0] && bcd_time == 24'h595999) |=> bcd_time == '0);
   a_r7_paused_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !running) |=> $stable(bcd_time));
   a_r1_clear_value: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> bcd_time == CLR_VALUE);
endmodule

// File: tb/stopwatch_core_tb.sv
`timescale 1ns/1ps
module stopwatch_core_tb;
   localparam int          CLK_HZ  = 2000;
   localparam int          DIV     = CLK_HZ / 1000;
   localparam logic [23:0] CLR_VAL = 24'h595900;
   localparam int          CLR_CS  = 59*6000 + 59*100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr_n = 1'b1;
   logic        start_stop = 1'b0;
   logic [23:0] bcd_time;
   logic        scan_tick;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   stopwatch_core #(.CLK_HZ(CLK_HZ), .COUNT_DIV(10), .CLR_VALUE(CLR_VAL)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .start_stop(start_stop),
      .bcd_time(bcd_time), .scan_tick(scan_tick)
   );

   function automatic logic [23:0] to_bcd(input int c);
      logic [23:0] r;
      r[23:20] = 4'(c / 60000);
      r[19:16] = 4'((c / 6000) % 10);
      r[15:12] = 4'((c / 1000) % 6);
      r[11:8]  = 4'((c / 100) % 10);
      r[7:4]   = 4'((c / 10) % 10);
      r[3:0]   = 4'(c % 10);
      return r;
   endfunction

   // behavioural reference, stepped on each rising edge
   int   m_pre, m_dec, m_cs;
   bit   m_run, m_valid;
   bit   m_h [3];
   always @(posedge clk) begin
      bit sc, ct, pr;
      if (!rst_n) begin
         m_pre = 0; m_dec = 0; m_run = 0; m_cs = CLR_CS; m_valid = 1;
         m_h[0] = 0; m_h[1] = 0; m_h[2] = 0;
      end else begin
         sc = (m_pre == DIV - 1);
         ct = sc && (m_dec == 9);
         pr = m_h[1] && !m_h[2];
         if (!clr_n) begin
            m_pre = 0; m_dec = 0; m_run = 0; m_cs = CLR_CS;
         end else begin
            if (m_run && ct) m_cs = (m_cs + 1) % 360000;
            m_pre = sc ? 0 : m_pre + 1;
            if (sc) m_dec = (m_dec == 9) ? 0 : m_dec + 1;
            if (pr) m_run = !m_run;
         end
         m_h[2] = m_h[1]; m_h[1] = m_h[0]; m_h[0] = start_stop;
      end
   end

   always @(negedge clk) begin
      if (m_valid) begin
         tests++;
         if (bcd_time !== to_bcd(m_cs)) begin
            fails++;
            $display("FAIL R3 per-cycle time: actual %h expected %h", bcd_time, to_bcd(m_cs));
         end
         tests++;
         if (scan_tick !== (m_pre == DIV - 1)) begin
            fails++;
            $display("FAIL R2 per-cycle scan_tick: actual %b expected %b", scan_tick, (m_pre == DIV - 1));
         end
      end
   end

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic press();
      @(negedge clk) start_stop = 1'b1;
      repeat (4) @(negedge clk);
      start_stop = 1'b0;
   endtask

   task automatic wait_for(input logic [23:0] v, input int limit, output bit ok);
      ok = 0;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (bcd_time == v) begin ok = 1; break; end
      end
   endtask

   task automatic next_change(output logic [23:0] v);
      logic [23:0] old;
      old = bcd_time;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (bcd_time != old) break;
      end
      v = bcd_time;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      bit ok;
      logic [23:0] v, snap;
      repeat (3) @(negedge clk);
      check("R1 reset value", bcd_time, CLR_VAL);
      rst_n = 1'b1;
      repeat (100) @(negedge clk);
      check("R6 no count before first press", bcd_time, CLR_VAL);
      check("R9 minutes tens field", {20'h0, bcd_time[23:20]}, 24'h5);
      check("R9 seconds units field", {20'h0, bcd_time[11:8]}, 24'h9);

      press();
      wait_for(24'h595999, 5000, ok);
      check("R3 reached 59:59.99", {23'h0, ok}, 24'h1);
      next_change(v);
      check("R5 rollover to zero", v, 24'h000000);

      wait_for(24'h000999, 25000, ok);
      check("R4 reached 00:09.99", {23'h0, ok}, 24'h1);
      next_change(v);
      check("R4 carry to 00:10.00", v, 24'h001000);
      next_change(v);
      check("R3 single hundredth step", v, 24'h001001);

      press();
      repeat (10) @(negedge clk);
      snap = bcd_time;
      repeat (200) @(negedge clk);
      check("R7 paused digits frozen", bcd_time, snap);

      press();
      repeat (60) @(negedge clk);
      check("R6 resume changes digits", {23'h0, (bcd_time != snap)}, 24'h1);

      @(negedge clk) clr_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 clear value", bcd_time, CLR_VAL);
      check("R8 scan held during clear", {23'h0, scan_tick}, 24'h0);
      clr_n = 1'b1;
      repeat (100) @(negedge clk);
      check("R1 paused after clear", bcd_time, CLR_VAL);

      press();
      next_change(v);
      check("R6 restart from clear value", v, 24'h595901);

      repeat (20) @(negedge clk);
      finish_run();
   end
endmodule